// File: doc/BRIEF.md
# D-Channel Access Status Generator

This block decides, for each time slot of a control channel shared by many subscriber lines, whether the addressed subscriber may use its D-channel. For every slot, the block takes three inputs: a channel index, the status code held for that channel in control memory, and the current state of an external access arbiter. It returns the code to be sent on that slot. Two enable registers hold one bit per channel. The primary enable vector is checked in every arbitrating state. The secondary enable vector is additionally checked in limited selection. In the frame-locked states, a separate index names the one channel still in play.

When the arbiter logic grants a channel, only the single status position is overridden, and that override is written as "available". Without a grant, the stored control-memory code passes unchanged, so software keeps it programmed as blocked. A coding bit chooses where the status lives. It is either a single MR bit (1 = available) or one bit of a 4-bit C/I nibble. In the nibble, bit 2 is 0 for available and 1 for blocked. The carrier that is not selected always passes its control-memory value unchanged. Writes to the enable registers are seen by the next slot, so clearing a bit blocks an active transmitter at once.

Top module: `dch_status_gen`

## Requirements
- R1: After reset, out_mr is 0, out_ci is 4'b0100, and both enable vectors are cleared, so no channel is granted.
- R2: Arbiter state SUSP (arb_state=1) with master_en=1 grants no channel; the control-memory code is sent unchanged.
- R3: State SUSP with master_en=0 grants every channel whose primary enable bit is 1.
- R4: State FULL (arb_state=2) grants a channel when its primary enable bit is 1, regardless of master_en.
- R5: State LIMIT (arb_state=3) grants a channel only when both its primary and secondary enable bits are 1.
- R6: States EXPECT (4) and RECV (5) grant only the channel equal to addr_ch, and only while its primary enable bit is 1.
- R7: State OFF (arb_state=0) grants channels by primary enable bit when master_en=1, and grants none when master_en=0.
- R8: With code_sel=0 (MR coding), a granted slot sends out_mr=1, an ungranted slot sends cm_mr, and out_ci always equals cm_ci.
- R9: With code_sel=1 (C/I coding), a granted slot sends cm_ci with bit 2 forced to 0, an ungranted slot sends cm_ci, and out_mr always equals cm_mr.
- R10: A write (wr_sel=0 primary, 1 secondary) is used by the slot presented on the following cycle; clearing a granted channel's bit makes that slot blocked.
- R11: Outputs are registered: a slot's result appears after the next rising clock edge and holds until the edge after that.
- R12: Arbiter state codes 6 and 7 grant no channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_ch | input | 5 | Channel index of the current slot |
| cm_mr | input | 1 | Control-memory MR bit for this channel |
| cm_ci | input | 4 | Control-memory C/I nibble for this channel |
| arb_state | input | 3 | Arbiter state: 0 OFF, 1 SUSP, 2 FULL, 3 LIMIT, 4 EXPECT, 5 RECV |
| addr_ch | input | 5 | Channel addressed in the frame-locked states |
| master_en | input | 1 | Control channel master enable |
| code_sel | input | 1 | 0 = status in MR bit, 1 = status in C/I bit 2 |
| wr_en | input | 1 | Enable register write strobe |
| wr_sel | input | 1 | 0 = primary enable, 1 = secondary enable |
| wr_data | input | 32 | Enable register write data, bit n for channel n |
| out_mr | output | 1 | MR bit to send for the slot |
| out_ci | output | 4 | C/I nibble to send for the slot |

## Verification
Directed slots visit each arbiter state with a channel that has a grant and a channel that does not. Setting the control-memory code to blocked makes a missing grant visible. Setting it to available makes a spurious override visible. The frame-locked states are probed on the addressed channel and on a neighbour, both with its enable set and cleared, which separates an index fault from an enable fault. Random slots over all states, codings, masters and enable patterns, with interleaved writes, expose errors in bit selection, in nibble bit copying and in write-to-slot timing.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    typedef enum logic [2:0] {
        ARB_OFF    = 3'd0,
        ARB_SUSP   = 3'd1,
        ARB_FULL   = 3'd2,
        ARB_LIMIT  = 3'd3,
        ARB_EXPECT = 3'd4,
        ARB_RECV   = 3'd5
    } arb_state_e;

    localparam int CI_W        = 4;
    localparam int CI_STAT_BIT = 2;

    typedef struct packed {
        logic            mr;
        logic [CI_W-1:0] ci;
    } slot_code_t;
endpackage

// File: rtl/dcs_enable_regs.sv
module dcs_enable_regs #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [NUM_CH-1:0] wr_data,
    output logic [NUM_CH-1:0] pri_o,
    output logic [NUM_CH-1:0] sec_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] pri;
        logic [NUM_CH-1:0] sec;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_sel) st_d.sec = wr_data;
            else        st_d.pri = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pri_o = st_q.pri;
    assign sec_o = st_q.sec;
endmodule

// File: rtl/dcs_grant.sv
module dcs_grant
    import dcs_pkg::*;
#(
    parameter int NUM_CH = 32,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic [IDX_W-1:0]  ch_i,
    input  logic [IDX_W-1:0]  addr_i,
    input  logic [2:0]        state_i,
    input  logic              master_i,
    input  logic [NUM_CH-1:0] pri_i,
    input  logic [NUM_CH-1:0] sec_i,
    output logic              grant_o
);
    logic [NUM_CH-1:0] grant_vec;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_comb begin
            case (arb_state_e'(state_i))
                ARB_OFF:    grant_vec[g] = master_i & pri_i[g];
                ARB_SUSP:   grant_vec[g] = ~master_i & pri_i[g];
                ARB_FULL:   grant_vec[g] = pri_i[g];
                ARB_LIMIT:  grant_vec[g] = pri_i[g] & sec_i[g];
                ARB_EXPECT,
                ARB_RECV:   grant_vec[g] = (addr_i == IDX_W'(g)) & pri_i[g];
                default:    grant_vec[g] = 1'b0;
            endcase
        end
    end

    assign grant_o = grant_vec[ch_i];
endmodule

// File: rtl/dcs_encode.sv
module dcs_encode
    import dcs_pkg::*;
(
    input  logic            grant_i,
    input  logic            code_sel_i,
    input  logic            cm_mr_i,
    input  logic [CI_W-1:0] cm_ci_i,
    output slot_code_t      code_o
);
    always_comb begin
        code_o.mr = cm_mr_i;
        code_o.ci = cm_ci_i;
        if (grant_i) begin
            if (code_sel_i) code_o.ci[CI_STAT_BIT] = 1'b0;
            else            code_o.mr = 1'b1;
        end
    end
endmodule

// File: rtl/dch_status_gen.sv
module dch_status_gen
    import dcs_pkg::*;
#(
    parameter int NUM_CH = 32,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  slot_ch,
    input  logic              cm_mr,
    input  logic [3:0]        cm_ci,
    input  logic [2:0]        arb_state,
    input  logic [IDX_W-1:0]  addr_ch,
    input  logic              master_en,
    input  logic              code_sel,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [NUM_CH-1:0] wr_data,
    output logic              out_mr,
    output logic [3:0]        out_ci
);
    logic [NUM_CH-1:0] dce_w;
    logic [NUM_CH-1:0] dces_w;
    logic              grant_w;
    slot_code_t        code_w;

    typedef struct packed {
        slot_code_t code;
    } out_state_t;

    out_state_t out_d, out_q;

    dcs_enable_regs #(.NUM_CH(NUM_CH)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pri_o   (dce_w),
        .sec_o   (dces_w)
    );

    dcs_grant #(.NUM_CH(NUM_CH)) i_grant (
        .ch_i     (slot_ch),
        .addr_i   (addr_ch),
        .state_i  (arb_state),
        .master_i (master_en),
        .pri_i    (dce_w),
        .sec_i    (dces_w),
        .grant_o  (grant_w)
    );

    dcs_encode i_enc (
        .grant_i    (grant_w),
        .code_sel_i (code_sel),
        .cm_mr_i    (cm_mr),
        .cm_ci_i    (cm_ci),
        .code_o     (code_w)
    );

    always_comb begin
        out_d      = out_q;
        out_d.code = code_w;
    end

    // R1: reset value is the blocked code on both carriers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.code.mr <= 1'b0;
            out_q.code.ci <= 4'b0100;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_mr = out_q.code.mr;
    assign out_ci = out_q.code.ci;
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
    parameter int NUM_CH = 32,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  slot_ch,
    input logic              cm_mr,
    input logic [3:0]        cm_ci,
    input logic [2:0]        arb_state,
    input logic [IDX_W-1:0]  addr_ch,
    input logic              master_en,
    input logic              code_sel,
    input logic [NUM_CH-1:0] dce,
    input logic [NUM_CH-1:0] dces,
    input logic              out_mr,
    input logic [3:0]        out_ci
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2
    susp_master_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(arb_state) == 3'd1 && $past(master_en)
        |-> out_mr == $past(cm_mr) && out_ci == $past(cm_ci));

    // R8
    mr_ci_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(code_sel) |-> out_ci == $past(cm_ci));

    // R9
    ci_other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(code_sel)
        |-> out_mr == $past(cm_mr) && out_ci[3] == $past(cm_ci[3])
            && out_ci[1:0] == $past(cm_ci[1:0]));

    // R6
    frame_other_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(arb_state) == 3'd4 || $past(arb_state) == 3'd5)
        && $past(slot_ch) != $past(addr_ch)
        |-> out_mr == $past(cm_mr) && out_ci == $past(cm_ci));

    // R5
    limit_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(arb_state) == 3'd3
        && !($past(dce[slot_ch]) && $past(dces[slot_ch]))
        |-> out_mr == $past(cm_mr) && out_ci == $past(cm_ci));

    // R12
    unused_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(arb_state) >= 3'd6
        |-> out_mr == $past(cm_mr) && out_ci == $past(cm_ci));
endmodule

bind dch_status_gen dcs_checker #(.NUM_CH(NUM_CH)) i_dcs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_ch   (slot_ch),
    .cm_mr     (cm_mr),
    .cm_ci     (cm_ci),
    .arb_state (arb_state),
    .addr_ch   (addr_ch),
    .master_en (master_en),
    .code_sel  (code_sel),
    .dce       (dce_w),
    .dces      (dces_w),
    .out_mr    (out_mr),
    .out_ci    (out_ci)
);

// File: tb/test_dch_status_gen.sv
`timescale 1ns/1ps
module test_dch_status_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  slot_ch = '0;
    logic        cm_mr = 1'b0;
    logic [3:0]  cm_ci = 4'b0100;
    logic [2:0]  arb_state = '0;
    logic [4:0]  addr_ch = '0;
    logic        master_en = 1'b0;
    logic        code_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        out_mr;
    logic [3:0]  out_ci;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_dce = '0;
    logic [31:0] m_dces = '0;

    always #2.5 clk = ~clk;

    dch_status_gen i_dch_status_gen (
        .clk(clk), .rst_n(rst_n), .slot_ch(slot_ch), .cm_mr(cm_mr), .cm_ci(cm_ci),
        .arb_state(arb_state), .addr_ch(addr_ch), .master_en(master_en),
        .code_sel(code_sel), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .out_mr(out_mr), .out_ci(out_ci)
    );

    function automatic logic grant_of(logic [2:0] st, logic m, logic [4:0] ch,
                                      logic [4:0] ad, logic [31:0] p, logic [31:0] s);
        case (st)
            3'd0: return m & p[ch];
            3'd1: return !m & p[ch];
            3'd2: return p[ch];
            3'd3: return p[ch] & s[ch];
            3'd4, 3'd5: return (ch == ad) & p[ch];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [4:0] expect_code(logic g, logic sel, logic mr, logic [3:0] ci);
        logic [4:0] r;
        r = {mr, ci};
        if (g) begin
            if (sel) r[2] = 1'b0;
            else     r[4] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(string req, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got {mr,ci}=%b expected %b", req, act, exp);
        end
    endtask

    // drive on negedge, write the enables in the same cycle, sample next negedge
    task automatic slot(string req, logic [2:0] st, logic m, logic sel, logic [4:0] ch,
                        logic [4:0] ad, logic mr, logic [3:0] ci);
        logic [4:0] exp;
        arb_state = st; master_en = m; code_sel = sel; slot_ch = ch;
        addr_ch = ad; cm_mr = mr; cm_ci = ci;
        exp = expect_code(grant_of(st, m, ch, ad, m_dce, m_dces), sel, mr, ci);
        @(posedge clk);
        @(negedge clk);
        check(req, {out_mr, out_ci}, exp);
    endtask

    task automatic write_en(logic sel, logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) m_dces = d; else m_dce = d;
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0d1c));
        repeat (3) @(negedge clk);
        // R1: reset value
        check("R1 reset", {out_mr, out_ci}, 5'b00100);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: enables cleared, full selection grants nothing
        slot("R1 cleared", 3'd2, 1'b0, 1'b0, 5'd7, 5'd0, 1'b0, 4'b1111);

        write_en(1'b0, 32'h0000_00F0);
        write_en(1'b1, 32'h0000_0030);
        // R2
        slot("R2 master on", 3'd1, 1'b1, 1'b0, 5'd4, 5'd0, 1'b0, 4'b0100);
        slot("R2 master on ci", 3'd1, 1'b1, 1'b1, 5'd5, 5'd0, 1'b1, 4'b1110);
        // R3
        slot("R3 enabled", 3'd1, 1'b0, 1'b0, 5'd5, 5'd0, 1'b0, 4'b0100);
        slot("R3 not enabled", 3'd1, 1'b0, 1'b0, 5'd8, 5'd0, 1'b0, 4'b0100);
        // R4
        slot("R4 enabled", 3'd2, 1'b1, 1'b0, 5'd7, 5'd0, 1'b0, 4'b0100);
        slot("R4 not enabled", 3'd2, 1'b0, 1'b1, 5'd3, 5'd0, 1'b1, 4'b0101);
        // R5
        slot("R5 both", 3'd3, 1'b0, 1'b0, 5'd4, 5'd0, 1'b0, 4'b0100);
        slot("R5 only pri", 3'd3, 1'b0, 1'b0, 5'd6, 5'd0, 1'b0, 4'b0100);
        // R6
        slot("R6 addressed", 3'd4, 1'b0, 1'b1, 5'd6, 5'd6, 1'b0, 4'b1111);
        slot("R6 other", 3'd5, 1'b0, 1'b1, 5'd7, 5'd6, 1'b0, 4'b1111);
        slot("R6 addressed off", 3'd5, 1'b0, 1'b0, 5'd2, 5'd2, 1'b0, 4'b0100);
        // R7
        slot("R7 master on", 3'd0, 1'b1, 1'b0, 5'd4, 5'd0, 1'b0, 4'b0100);
        slot("R7 master off", 3'd0, 1'b0, 1'b0, 5'd4, 5'd0, 1'b0, 4'b0100);
        // R8 and R9
        slot("R8 mr carrier", 3'd2, 1'b0, 1'b0, 5'd5, 5'd0, 1'b0, 4'b1110);
        slot("R9 ci carrier", 3'd2, 1'b0, 1'b1, 5'd5, 5'd0, 1'b0, 4'b1110);
        // R12
        slot("R12 state6", 3'd6, 1'b0, 1'b0, 5'd5, 5'd0, 1'b0, 4'b0100);
        slot("R12 state7", 3'd7, 1'b1, 1'b1, 5'd4, 5'd0, 1'b1, 4'b0100);

        // R10: write clearing channel 5 during a granted run blocks the next slot
        slot("R10 before clear", 3'd2, 1'b0, 1'b0, 5'd5, 5'd0, 1'b0, 4'b0100);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_00D0;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 same-cycle old", {out_mr, out_ci}, 5'b10100);
        m_dce = 32'h0000_00D0;
        slot("R10 after clear", 3'd2, 1'b0, 1'b0, 5'd5, 5'd0, 1'b0, 4'b0100);

        // R11: new inputs not visible before the edge
        slot("R11 setup", 3'd2, 1'b0, 1'b0, 5'd4, 5'd0, 1'b0, 4'b0100);
        slot_ch = 5'd9; cm_ci = 4'b1011;
        #1;
        check("R11 hold", {out_mr, out_ci}, 5'b10100);
        @(posedge clk);
        #1;
        check("R11 update", {out_mr, out_ci}, 5'b01011);
        @(negedge clk);

        // random mix, R3 R4 R5 R6 R8 R9 R10
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 7) == 0)
                write_en(1'($urandom_range(0, 1)), $urandom);
            slot("R4 random", 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)),
                 5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)),
                 4'($urandom_range(0, 15)));
        end
        finish_run();
    end
endmodule